// File: doc/BRIEF.md
# Serial Channel Register Core

This block is the host-facing register logic of one channel of a two-channel UART. A byte-wide bus reaches three locations: a mode location that alternates between two mode registers, a location that reads as status and takes commands when written, and a data location that pops the receive queue on read and loads the transmitter on write. Received characters come in on a one-cycle valid/data strobe from a deserializer outside the block. Transmitted characters leave on a one-cycle valid/data strobe to a serializer outside the block.

The channel holds a small receive queue, a transmit-ready handshake that models the time a character spends in the serializer, a flag that asks a DMA engine for transmit data, and a local loopback mode in which host writes to the data location land in the channel's own receive queue. Bit timing, shifting, framing and parity are handled elsewhere. The parity and framing error bits are reserved and always read 0; the overrun bit is the only error bit the block sets.

Top module: `duart_chan_core`

## Requirements
- R1: Address 0 reaches mode register 1 or mode register 2 through a one-bit pointer that resets to mode register 1; every read or write there acts on the selected register and then flips the pointer, so it wraps from 2 back to 1. A command with bits 6:4 equal to 1 returns the pointer to mode register 1.
- R2: A write to address 1 is a command: bit 0 enables the receiver, bit 1 disables it, bit 2 enables the transmitter, bit 3 disables it; when both bits of one side are set, the disable takes effect.
- R3: Enabling the transmitter sets TxRDY and TxEMT and raises `dma_req`; disabling it clears all three.
- R4: Disabling the receiver clears RxRDY and leaves queued bytes in place; command bits 6:4 equal to 2 disable the receiver, clear RxRDY and empty the receive queue.
- R5: Command bits 6:4 equal to 3 disable the transmitter and clear TxRDY, TxEMT and `dma_req`; equal to 4 they clear the error bits of the status byte.
- R6: The receive queue holds FIFO_DEPTH (default 3) bytes; an arriving byte is stored only while the receiver is enabled, storing sets RxRDY, and FFULL is set when the queue becomes full.
- R7: A read of address 2 returns the oldest byte, removes it, and clears RxRDY and FFULL; one cycle later RxRDY is set again if bytes remain.
- R8: A byte that arrives with the receiver enabled and the queue full is dropped and sets the overrun bit.
- R9: When mode register 2 bits 7:6 equal binary 10 the channel loops back: a write of address 2 stores the byte in the receive queue unless FFULL is set, always sets RxRDY, sends nothing on `tx_valid`, and bytes on `rx_valid` are ignored.
- R10: Outside loopback, a write of address 2 while the transmitter is enabled and TxRDY is set emits the byte on `tx_valid` for one cycle in the following cycle and clears TxRDY and TxEMT for TX_HOLD cycles; a write while disabled or busy emits nothing.
- R11: The status byte read at address 1 has RxRDY in bit 0, FFULL in bit 1, TxRDY in bit 2, TxEMT in bit 3, overrun in bit 4 and zeros in bits 7:5; after reset it reads 0, both sides are disabled and `dma_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 2 | Register address: 0 mode, 1 status/command, 2 data |
| bus_wr | input | 1 | Write strobe, one access per cycle, wins over a read |
| bus_rd | input | 1 | Read strobe; side effects occur at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| rx_valid | input | 1 | One-cycle strobe of a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle strobe of a byte to send |
| tx_data | output | 8 | Byte to send |
| dma_req | output | 1 | Transmit DMA request flag |

## Verification
The hardest states to reach from the ports are those where the queue is full while status bits disagree with its contents: a full queue with the receiver disabled, where RxRDY is low yet FFULL is high, and a loopback write that finds the queue full but must still set RxRDY. The stimulus reaches them by filling the queue from the receive strobe, disabling the receiver with a command, switching mode register 2 into loopback and writing the data location, and the random phase mixes command bytes with random extra-action codes among receive bursts and reads so that flushes, overruns and re-asserted RxRDY occur with the queue at every fill level.

// File: rtl/uchan_pkg.sv
// Shared constants and the status layout of the serial channel core.
// Assumes a two-bit register address and byte-wide data.
package uchan_pkg;
    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    localparam int CB_RXON  = 0;
    localparam int CB_RXOFF = 1;
    localparam int CB_TXON  = 2;
    localparam int CB_TXOFF = 3;

    localparam logic [2:0] XA_PTR_MR1 = 3'd1;
    localparam logic [2:0] XA_RX_RST  = 3'd2;
    localparam logic [2:0] XA_TX_RST  = 3'd3;
    localparam logic [2:0] XA_ERR_CLR = 3'd4;

    localparam logic [1:0] LOOP_CODE = 2'b10;

    typedef struct packed {
        logic spare;
        logic frm_err;
        logic par_err;
        logic ovr_err;
        logic txemt;
        logic txrdy;
        logic ffull;
        logic rxrdy;
    } chan_status_t;
endpackage

// File: rtl/uchan_mode_regs.sv
// Two mode registers behind one address, chosen by a toggling pointer.
// Assumes wr and rd are never asserted together (the top resolves that).
module uchan_mode_regs
    import uchan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       rd,
    input  logic       ptr_clr,
    input  logic [7:0] wdata,
    output logic [7:0] sel_q,
    output logic       loopback
);
    logic       ptr_q;
    logic [7:0] mr1_q;
    logic [7:0] mr2_q;

    // Store into the selected register and step the pointer on each access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= 1'b0;
            mr1_q <= '0;
            mr2_q <= '0;
        end else begin
            if (wr && !ptr_q) mr1_q <= wdata;
            if (wr && ptr_q)  mr2_q <= wdata;
            if (ptr_clr)          ptr_q <= 1'b0;
            else if (wr || rd)    ptr_q <= ~ptr_q;
        end
    end

    assign sel_q    = ptr_q ? mr2_q : mr1_q;
    assign loopback = (mr2_q[7:6] == LOOP_CODE);

    // R1: each access flips the pointer unless a pointer reset arrives.
    p_ptr_steps_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr || rd) && !ptr_clr |=> ptr_q != $past(ptr_q));
    p_ptr_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_clr |=> !ptr_q);
endmodule

// File: rtl/uchan_rx_fifo.sv
// Receive queue with wrapping read/write pointers and a full flag.
// Assumes DEPTH >= 2; a pop always clears the full flag.
module uchan_rx_fifo #(
    parameter int DEPTH = 3,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] pdata,
    input  logic         pop,
    input  logic         flush,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wp_q;
    logic [PTR_W-1:0] rp_q;
    logic             full_q;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (wp_q == rp_q) && !full_q;
    assign full    = full_q;
    assign do_push = push && !full_q;
    assign do_pop  = pop && !empty;
    assign head    = mem_q[rp_q];

    // Keep pointers and the full flag.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q   <= '0;
            rp_q   <= '0;
            full_q <= 1'b0;
        end else begin
            if (do_push) wp_q <= step(wp_q);
            if (do_pop)  rp_q <= step(rp_q);
            if (pop)                                   full_q <= 1'b0;
            else if (do_push && step(wp_q) == rp_q)    full_q <= 1'b1;
        end
    end

    // Write storage; no reset needed for data.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wp_q] <= pdata;
    end

    // R6: a full queue never advances its write pointer.
    p_full_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_q && !flush |=> $stable(wp_q));
    // R7: a pop leaves the queue not full.
    p_pop_unfull_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !full_q);
endmodule

// File: rtl/uchan_tx_path.sv
// Transmit holding stage: one-cycle output strobe and a busy window.
// Assumes send is only raised while the channel reports ready.
module uchan_tx_path #(
    parameter int HOLD = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       send,
    input  logic [7:0] sdata,
    input  logic       kill,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       done
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;

    // Emit the byte and time the busy window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
            cnt_q    <= '0;
        end else begin
            tx_valid <= send;
            if (send) tx_data <= sdata;
            if (kill)               cnt_q <= '0;
            else if (send)          cnt_q <= CW'(HOLD);
            else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
        end
    end

    assign done = (cnt_q == CW'(1)) && !kill;

    // R10: the output strobe never lasts two cycles.
    p_one_beat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);
endmodule

// File: rtl/duart_chan_core.sv
// Register core of one UART channel: mode pair, command decode, status,
// receive queue, transmit holding and loopback. A write wins over a read
// in the same cycle; bus_rdata is a combinational view of the state.
module duart_chan_core
    import uchan_pkg::*;
#(
    parameter int FIFO_DEPTH = 3,
    parameter int TX_HOLD    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       dma_req
);
    logic       wr_mode, rd_mode, wr_cmd, wr_data, rd_data;
    logic [2:0] xact;
    logic       rx_stop, rx_start, tx_stop, tx_start;
    logic       loopback, lb_push, rx_push, push, send, done;
    logic       fifo_empty, fifo_full;
    logic [7:0] fifo_head, mode_q;
    logic       rx_en_q, tx_en_q, rxrdy_q, txrdy_q, txemt_q, ovr_q, rd_prev_q;
    chan_status_t st;

    // Decode the bus access.
    assign wr_mode = bus_wr && (bus_addr == A_MODE);
    assign rd_mode = bus_rd && !bus_wr && (bus_addr == A_MODE);
    assign wr_cmd  = bus_wr && (bus_addr == A_CTRL);
    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign rd_data = bus_rd && !bus_wr && (bus_addr == A_DATA);
    assign xact    = bus_wdata[6:4];

    assign rx_stop  = wr_cmd && (bus_wdata[CB_RXOFF] || xact == XA_RX_RST);
    assign rx_start = wr_cmd && bus_wdata[CB_RXON] && !rx_stop;
    assign tx_stop  = wr_cmd && (bus_wdata[CB_TXOFF] || xact == XA_TX_RST);
    assign tx_start = wr_cmd && bus_wdata[CB_TXON] && !tx_stop;

    assign lb_push = wr_data && loopback;
    assign rx_push = rx_valid && rx_en_q && !loopback;
    assign push    = lb_push || rx_push;
    assign send    = wr_data && !loopback && tx_en_q && txrdy_q;

    uchan_mode_regs u_mode (
        .clk(clk), .rst_n(rst_n), .wr(wr_mode), .rd(rd_mode),
        .ptr_clr(wr_cmd && xact == XA_PTR_MR1), .wdata(bus_wdata),
        .sel_q(mode_q), .loopback(loopback)
    );

    uchan_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push),
        .pdata(lb_push ? bus_wdata : rx_data), .pop(rd_data),
        .flush(wr_cmd && xact == XA_RX_RST), .head(fifo_head),
        .empty(fifo_empty), .full(fifo_full)
    );

    uchan_tx_path #(.HOLD(TX_HOLD)) u_tx (
        .clk(clk), .rst_n(rst_n), .send(send), .sdata(bus_wdata),
        .kill(tx_stop), .tx_valid(tx_valid), .tx_data(tx_data), .done(done)
    );

    // Receiver enable, RxRDY with its post-read re-assertion, and overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_en_q   <= 1'b0;
            rxrdy_q   <= 1'b0;
            ovr_q     <= 1'b0;
            rd_prev_q <= 1'b0;
        end else begin
            rd_prev_q <= rd_data;
            if (rx_stop)        rx_en_q <= 1'b0;
            else if (rx_start)  rx_en_q <= 1'b1;
            if (rx_stop)                              rxrdy_q <= 1'b0;
            else if ((push && !fifo_full) || lb_push) rxrdy_q <= 1'b1;
            else if (rd_data)                         rxrdy_q <= 1'b0;
            else if (rd_prev_q && !fifo_empty)        rxrdy_q <= 1'b1;
            if (wr_cmd && xact == XA_ERR_CLR)   ovr_q <= 1'b0;
            else if (rx_push && fifo_full)      ovr_q <= 1'b1;
        end
    end

    // Transmitter enable, ready/empty handshake and DMA request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            txrdy_q <= 1'b0;
            txemt_q <= 1'b0;
            dma_req <= 1'b0;
        end else if (tx_stop) begin
            tx_en_q <= 1'b0;
            txrdy_q <= 1'b0;
            txemt_q <= 1'b0;
            dma_req <= 1'b0;
        end else if (tx_start) begin
            tx_en_q <= 1'b1;
            txrdy_q <= 1'b1;
            txemt_q <= 1'b1;
            dma_req <= 1'b1;
        end else if (send) begin
            txrdy_q <= 1'b0;
            txemt_q <= 1'b0;
        end else if (done && tx_en_q) begin
            txrdy_q <= 1'b1;
            txemt_q <= 1'b1;
        end
    end

    // Assemble status and select read data.
    always_comb begin
        st         = '0;
        st.rxrdy   = rxrdy_q;
        st.ffull   = fifo_full;
        st.txrdy   = txrdy_q;
        st.txemt   = txemt_q;
        st.ovr_err = ovr_q;
        case (bus_addr)
            A_MODE:  bus_rdata = mode_q;
            A_CTRL:  bus_rdata = st;
            A_DATA:  bus_rdata = fifo_head;
            default: bus_rdata = '0;
        endcase
    end

    // R2: with both transmitter bits set the transmitter ends up off.
    p_disable_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_CTRL && bus_wdata[CB_TXON] && bus_wdata[CB_TXOFF]
        |=> !dma_req && !txrdy_q);
    // R3: a plain transmitter enable raises ready, empty and DMA request.
    p_tx_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_CTRL && bus_wdata[CB_TXON] && !bus_wdata[CB_TXOFF]
        && bus_wdata[6:4] != XA_TX_RST |=> dma_req && txrdy_q && txemt_q);
    // R4: a receiver disable leaves RxRDY low.
    p_rx_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_CTRL && bus_wdata[CB_RXOFF] |=> !rxrdy_q);
    // R8: a byte meeting a full queue flags overrun.
    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && rx_en_q && !loopback && fifo_full && !wr_cmd |=> ovr_q);
    // R9: loopback writes never reach the transmit strobe.
    p_loop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_DATA && loopback |=> !tx_valid);
    // R10: the channel is not ready while a byte is leaving.
    p_busy_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !txrdy_q && !txemt_q);
endmodule

// File: tb/test_duart_chan_core.sv
// Self-checking bench: directed corners, then seeded random operations
// compared against a behavioural model kept in bench variables.
module test_duart_chan_core;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 3;
    localparam int HOLD       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       dma_req;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic [7:0] m_q [DEPTH];
    int         m_cnt = 0;
    logic m_rxen = 0, m_txen = 0, m_txrdy = 0, m_dma = 0, m_ovr = 0, m_rxrdy = 0;
    logic [7:0] m_mr1 = 0, m_mr2 = 0;
    logic m_ptr = 0;

    duart_chan_core #(.FIFO_DEPTH(DEPTH), .TX_HOLD(HOLD)) i_duart_chan_core (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_valid(tx_valid),
        .tx_data(tx_data), .dma_req(dma_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic m_loop();
        return m_mr2[7:6] == 2'b10;
    endfunction

    function automatic logic [7:0] exp_st();
        return {3'b000, m_ovr, m_txrdy, m_txrdy, (m_cnt == DEPTH), m_rxrdy};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic peek(output logic [7:0] v);
        bus_addr = 2'd1;
        #1;
        v = bus_rdata;
    endtask

    task automatic settle_check();
        logic [7:0] s;
        peek(s);
        chk("R11 status byte", s, exp_st());
        chk("R3 dma_req", dma_req, m_dma);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic m_push(input logic [7:0] b);
        if (m_cnt < DEPTH) begin
            m_q[m_cnt] = b;
            m_cnt++;
        end
    endtask

    task automatic op_rx(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        tick();
        rx_valid = 1'b0;
        if (m_rxen && !m_loop()) begin
            if (m_cnt < DEPTH) begin m_push(b); m_rxrdy = 1; end
            else m_ovr = 1;
        end
        tick();
        settle_check();
    endtask

    task automatic op_read();
        logic [7:0] s;
        bus_addr = 2'd2; bus_rd = 1'b1;
        #1;
        if (m_cnt > 0) chk("R7 oldest byte", bus_rdata, m_q[0]);
        tick();
        bus_rd = 1'b0;
        if (m_cnt > 0) begin
            for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i + 1];
            m_cnt--;
        end
        peek(s);
        chk("R7 RxRDY low after read", s[0], 1'b0);
        chk("R7 FFULL low after read", s[1], 1'b0);
        tick();
        m_rxrdy = (m_cnt > 0);
        settle_check();
    endtask

    task automatic op_write(input logic [7:0] b);
        logic [7:0] s;
        logic go;
        go = !m_loop() && m_txen && m_txrdy;
        bus_write(2'd2, b);
        if (m_loop()) begin
            m_push(b);
            m_rxrdy = 1;
            chk("R9 no transmit in loopback", tx_valid, 1'b0);
        end else if (go) begin
            chk("R10 tx_valid", tx_valid, 1'b1);
            chk("R10 tx_data", tx_data, b);
            peek(s);
            chk("R10 busy clears TxRDY/TxEMT", s[3:2], 2'b00);
            repeat (HOLD - 1) tick();
            chk("R10 single strobe", tx_valid, 1'b0);
            peek(s);
            chk("R10 still busy", s[3:2], 2'b00);
            tick();
            peek(s);
            chk("R10 ready again", s[3:2], 2'b11);
        end else begin
            chk("R10 write ignored", tx_valid, 1'b0);
        end
        tick();
        settle_check();
    endtask

    task automatic op_cmd(input logic [7:0] v);
        bus_write(2'd1, v);
        if (v[1]) begin m_rxen = 0; m_rxrdy = 0; end
        else if (v[0]) m_rxen = 1;
        if (v[3]) begin m_txen = 0; m_txrdy = 0; m_dma = 0; end
        else if (v[2]) begin m_txen = 1; m_txrdy = 1; m_dma = 1; end
        case (v[6:4])
            3'd1: m_ptr = 0;
            3'd2: begin m_rxen = 0; m_rxrdy = 0; m_cnt = 0; end
            3'd3: begin m_txen = 0; m_txrdy = 0; m_dma = 0; end
            3'd4: m_ovr = 0;
            default: ;
        endcase
        tick();
        settle_check();
    endtask

    task automatic op_mode_wr(input logic [7:0] v);
        bus_write(2'd0, v);
        if (m_ptr) m_mr2 = v; else m_mr1 = v;
        m_ptr = ~m_ptr;
        tick();
        settle_check();
    endtask

    task automatic op_mode_rd();
        bus_addr = 2'd0; bus_rd = 1'b1;
        #1;
        chk("R1 mode read", bus_rdata, m_ptr ? m_mr2 : m_mr1);
        tick();
        bus_rd = 1'b0;
        m_ptr = ~m_ptr;
        tick();
        settle_check();
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] s;
        void'($urandom(32'h5eed_0071));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        peek(s);
        chk("R11 reset status", s, 8'h00);
        chk("R11 reset dma_req", dma_req, 1'b0);
        chk("R11 reset tx_valid", tx_valid, 1'b0);

        // R1 pointer stepping, wrap and reset by command
        op_mode_wr(8'h13);
        op_mode_wr(8'h07);
        op_mode_rd(); op_mode_rd(); op_mode_rd();
        op_cmd(8'h10);
        op_mode_rd();
        op_cmd(8'h10);

        // R3 enable both sides
        op_cmd(8'h05);
        peek(s);
        chk("R3 TxRDY and TxEMT set", s[3:2], 2'b11);

        // R6 fill, R8 overrun
        op_rx(8'hA1); op_rx(8'hA2); op_rx(8'hA3);
        peek(s);
        chk("R6 FFULL when full", s[1], 1'b1);
        op_rx(8'hA4);
        peek(s);
        chk("R8 overrun set", s[4], 1'b1);
        op_read(); op_read(); op_read();
        peek(s);
        chk("R7 RxRDY stays low when empty", s[0], 1'b0);

        // R5 clear errors
        op_cmd(8'h40);
        peek(s);
        chk("R5 error bits cleared", s[6:4], 3'b000);

        // R2 disable wins on both sides
        op_cmd(8'h0C);
        chk("R2 tx disable wins", dma_req, 1'b0);
        op_cmd(8'h03);
        op_rx(8'hB0);
        peek(s);
        chk("R6 byte ignored while receiver off", s[1:0], 2'b00);

        // R10 transmit timing and ignored writes
        op_cmd(8'h05);
        op_write(8'h5A);
        op_cmd(8'h08);
        op_write(8'h66);

        // R4 disable keeps data, flush empties
        op_rx(8'hC1); op_rx(8'hC2); op_rx(8'hC3);
        op_cmd(8'h02);
        peek(s);
        chk("R4 RxRDY low, data kept", s[1:0], 2'b10);
        op_cmd(8'h20);
        peek(s);
        chk("R4 flush empties queue", s[1:0], 2'b00);
        op_rx(8'hC4);

        // R9 loopback: fill, drop, ignore rx strobe
        op_cmd(8'h10);
        op_mode_wr(8'h00);
        op_mode_wr(8'h80);
        op_cmd(8'h05);
        op_write(8'hD1); op_write(8'hD2); op_write(8'hD3); op_write(8'hD4);
        op_rx(8'hEE);
        peek(s);
        chk("R9 loopback full, no overrun", s[4], 1'b0);
        op_read(); op_read(); op_read();

        // R5 transmitter reset
        op_cmd(8'h30);
        chk("R5 tx reset drops dma_req", dma_req, 1'b0);

        // back to normal mode
        op_cmd(8'h10);
        op_mode_wr(8'h00);
        op_mode_wr(8'h00);
        op_cmd(8'h05);

        // random phase
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 25)      op_rx(8'($urandom));
            else if (r < 45) op_read();
            else if (r < 65) op_write(8'($urandom));
            else if (r < 75) begin
                int x;
                logic [2:0] xa;
                x = int'($urandom % 10);
                xa = (x < 6) ? 3'd0 : 3'(x - 5);
                op_cmd({1'b0, xa, 4'($urandom)});
            end
            else if (r < 83) op_mode_wr(8'($urandom));
            else if (r < 90) op_mode_rd();
            else             settle_check();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule